// File: doc/BRIEF.md
# I2C Target Receiver with Address Filtering

This block is the receive side of an I2C target. It samples the raw SCL and SDA lines on the system clock and finds START and STOP conditions. It then takes in the first byte after each START as an address and checks its upper seven bits against two patterns: a fixed address, and a second address with a per-bit ignore mask. When one of them matches, the block pulls SDA low during the acknowledge slot of the address and of each byte the controller writes. Each byte is stored in a small receive queue together with tag bits. Software can then see where each transaction began and ended.

In capture mode the block never drives the bus. It records every byte it sees, together with the acknowledge level another device put on the line, and it marks the next stored entry when the queue had to drop something. Software pops entries through a one-cycle read strobe. An empty queue returns an entry whose empty bit is set.

Top module: `i2c_srx`

## Requirements
- R1: START (SDA falls while SCL is high) moves `state_o` to 1; the acknowledge slot after the address shows 2, data bit collection shows 3 and the data acknowledge slot shows 4; STOP (SDA rises while SCL is high) returns it to 0. Reset value is 0.
- R2: With `own_en_i` set, an address byte whose bits 7:1 equal `own_addr_i` is acknowledged (SDA held low in the ninth clock), and so is every following written byte.
- R3: With `alt_en_i` set, an address matches when it agrees with `alt_addr_i` in every bit position where `alt_mask_i` is 0.
- R4: An address that matches neither enabled pattern is not acknowledged, stores nothing, and its following STOP stores nothing.
- R5: A read entry is 13 bits: data in 7:0, empty in 8, overflow in 9, start-before in 10, stop in 11, not-acknowledged in 12. The address byte entry has bit 10 set. A STOP after a selected address gives an entry with only bit 11 set and data 0. Bit 12 holds the SDA level seen in that byte's ninth clock.
- R6: With `promisc_i` set, the block never drives SDA and stores every address byte, data byte and STOP, whatever the address.
- R7: In capture mode, an entry dropped because the queue is full sets bit 9 on the next entry that is stored. Outside capture mode bit 9 is never set.
- R8: Outside capture mode, a byte that arrives while the queue is full is not acknowledged and is discarded.
- R9: `rx_not_empty_o` is high while the queue holds an entry. `rx_full_o` is high while it holds `FIFO_DEPTH` entries.
- R10: After a selected address, `busy_write_o` (R/W bit 0) or `busy_read_o` (R/W bit 1) stays high until the next START or STOP.
- R11: A pulse on `fifo_clr_i` empties the queue and clears any pending overflow mark.
- R12: With `enable_i` low, the block does not acknowledge anything, stores nothing and stays in state 0.
- R13: A pulse on `rd_en_i` removes the head entry. An empty queue reads as 0x100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line |
| sda_oe_o | output | 1 | Pull SDA low when high |
| enable_i | input | 1 | Target interface enable |
| own_en_i | input | 1 | Fixed address match enable |
| own_addr_i | input | 7 | Fixed address |
| alt_en_i | input | 1 | Masked address match enable |
| alt_addr_i | input | 7 | Masked address pattern |
| alt_mask_i | input | 7 | Ignore mask for the pattern, 1 = don't care |
| promisc_i | input | 1 | Passive capture of all traffic |
| fifo_clr_i | input | 1 | Clear receive queue |
| rd_en_i | input | 1 | Pop head entry |
| rd_data_o | output | 13 | Head entry with tags |
| rx_not_empty_o | output | 1 | Queue holds data |
| rx_full_o | output | 1 | Queue is full |
| busy_write_o | output | 1 | Selected write transaction open |
| busy_read_o | output | 1 | Selected read transaction open |
| state_o | output | 3 | Receiver state code |

## Verification
A wrong bit count or a wrong state shows up within one byte time. Either the acknowledge is missing or misplaced in the ninth clock, or the stored data word is shifted. A wrong tag or overflow flag only shows when the entry is popped, so the bench pops and compares every entry against a queue model after each transaction. A stale selection flag shows at the next STOP as an extra or missing stop entry, and as a busy flag that stays high.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_START    = 3'd1,
    ST_ADDR_ACK = 3'd2,
    ST_DATA     = 3'd3,
    ST_DATA_ACK = 3'd4
  } srx_state_e;

  typedef struct packed {
    logic              nack;
    logic              stop;
    logic              start;
    logic              ovf;
    logic [BYTE_W-1:0] data;
  } srx_entry_t;

  localparam int unsigned ENTRY_W = $bits(srx_entry_t);
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '1;  // idle bus is high
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_srx_cond.sv
module i2c_srx_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_srx_match.sv
module i2c_srx_match #(
  parameter int unsigned AW = 7
) (
  input  logic [AW-1:0] addr_i,
  input  logic          own_en_i,
  input  logic [AW-1:0] own_addr_i,
  input  logic          alt_en_i,
  input  logic [AW-1:0] alt_addr_i,
  input  logic [AW-1:0] alt_mask_i,
  output logic          hit_o
);
  logic own_hit, alt_hit;

  assign own_hit = own_en_i && (addr_i == own_addr_i);
  // mask bit set = position ignored
  assign alt_hit = alt_en_i && (((addr_i ^ alt_addr_i) & ~alt_mask_i) == '0);
  assign hit_o   = own_hit | alt_hit;
endmodule

// File: rtl/i2c_srx_fifo.sv
module i2c_srx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rd_data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          do_wr, do_rd;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CW'(DEPTH));
  assign do_wr     = wr_en_i & ~full_o & ~clr_i;
  assign do_rd     = rd_en_i & ~empty_o & ~clr_i;
  assign rd_data_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wr_ptr_q] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + AW'(1);
      if (do_rd) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_push_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> !full_o);
  assert_clr_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
  assert_full_not_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
endmodule

// File: rtl/i2c_srx.sv
module i2c_srx
  import i2c_srx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              enable_i,
  input  logic              own_en_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              alt_en_i,
  input  logic [ADDR_W-1:0] alt_addr_i,
  input  logic [ADDR_W-1:0] alt_mask_i,
  input  logic              promisc_i,
  input  logic              fifo_clr_i,
  input  logic              rd_en_i,
  output logic [ENTRY_W:0]  rd_data_o,
  output logic              rx_not_empty_o,
  output logic              rx_full_o,
  output logic              busy_write_o,
  output logic              busy_read_o,
  output logic [2:0]        state_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, addr_hit;
  srx_state_e        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shreg_q;
  logic ack_q, keep_q, first_q, sel_q, rd_q, ovf_pend_q, bsy_w_q, bsy_r_q;
  logic push_req, fifo_wr, fifo_full, fifo_empty;
  srx_entry_t push_ent, head_ent;
  logic in_ack;

  i2c_srx_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   ({scl_s, sda_s})
  );

  i2c_srx_cond u_cond (
    .clk_i     (clk_i), .rst_ni(rst_ni),
    .scl_s_i   (scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o   (start_det), .stop_o(stop_det)
  );

  i2c_srx_match #(.AW(ADDR_W)) u_match (
    .addr_i    (shreg_q[BYTE_W-1:1]),
    .own_en_i  (own_en_i), .own_addr_i(own_addr_i),
    .alt_en_i  (alt_en_i), .alt_addr_i(alt_addr_i), .alt_mask_i(alt_mask_i),
    .hit_o     (addr_hit)
  );

  assign in_ack = (state_q == ST_ADDR_ACK) || (state_q == ST_DATA_ACK);

  always_comb begin
    push_req = 1'b0;
    push_ent = '0;
    if (enable_i) begin
      if (stop_det) begin
        push_req      = sel_q;
        push_ent.stop = 1'b1;
      end else if (!start_det && scl_rise && in_ack && keep_q) begin
        push_req       = 1'b1;
        push_ent.data  = shreg_q;
        push_ent.nack  = sda_s;  // level seen in the ninth clock
        push_ent.start = first_q;
      end
    end
    push_ent.ovf = ovf_pend_q & promisc_i;
  end

  assign fifo_wr = push_req & ~fifo_full & ~fifo_clr_i;

  i2c_srx_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk_i    (clk_i), .rst_ni(rst_ni),
    .clr_i    (fifo_clr_i),
    .wr_en_i  (fifo_wr), .wr_data_i(push_ent),
    .rd_en_i  (rd_en_i), .rd_data_o(head_ent),
    .empty_o  (fifo_empty), .full_o(fifo_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_pend_q <= 1'b0;
    end else if (fifo_clr_i || !promisc_i) begin
      ovf_pend_q <= 1'b0;
    end else if (push_req && fifo_full) begin
      ovf_pend_q <= 1'b1;
    end else if (fifo_wr) begin
      ovf_pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      ack_q     <= 1'b0;
      keep_q    <= 1'b0;
      first_q   <= 1'b0;
      sel_q     <= 1'b0;
      rd_q      <= 1'b0;
      bsy_w_q   <= 1'b0;
      bsy_r_q   <= 1'b0;
    end else if (!enable_i) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      ack_q     <= 1'b0;
      keep_q    <= 1'b0;
      first_q   <= 1'b0;
      sel_q     <= 1'b0;
      rd_q      <= 1'b0;
      bsy_w_q   <= 1'b0;
      bsy_r_q   <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      keep_q  <= 1'b0;
      sel_q   <= 1'b0;
      bsy_w_q <= 1'b0;
      bsy_r_q <= 1'b0;
    end else if (start_det) begin
      state_q   <= ST_START;
      bit_cnt_q <= '0;
      ack_q     <= 1'b0;
      keep_q    <= 1'b0;
      first_q   <= 1'b1;
      sel_q     <= promisc_i;
      bsy_w_q   <= 1'b0;
      bsy_r_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_START, ST_DATA: begin
          if (scl_rise && bit_cnt_q < LAST_BIT) begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s};
            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
          end else if (scl_fall && bit_cnt_q == LAST_BIT) begin
            if (state_q == ST_START) begin
              rd_q <= shreg_q[0];
              if (promisc_i || (addr_hit && !fifo_full)) begin
                sel_q   <= 1'b1;
                keep_q  <= 1'b1;
                ack_q   <= ~promisc_i;
                bsy_r_q <= shreg_q[0];
                bsy_w_q <= ~shreg_q[0];
                state_q <= ST_ADDR_ACK;
              end else begin
                sel_q   <= 1'b0;
                state_q <= ST_IDLE;
              end
            end else begin
              // full queue outside capture: refuse and drop the byte
              keep_q  <= promisc_i | ~fifo_full;
              ack_q   <= ~promisc_i & ~fifo_full;
              state_q <= ST_DATA_ACK;
            end
          end
        end
        ST_ADDR_ACK, ST_DATA_ACK: begin
          if (scl_rise) keep_q <= 1'b0;
          if (scl_fall) begin
            ack_q     <= 1'b0;
            bit_cnt_q <= '0;
            first_q   <= 1'b0;
            state_q   <= (promisc_i || !rd_q) ? ST_DATA : ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o       = ack_q;
  assign state_o        = state_q;
  assign busy_write_o   = bsy_w_q;
  assign busy_read_o    = bsy_r_q;
  assign rx_not_empty_o = ~fifo_empty;
  assign rx_full_o      = fifo_full;
  assign rd_data_o      = fifo_empty ? {4'b0000, 1'b1, {BYTE_W{1'b0}}}
                                     : {head_ent.nack, head_ent.stop, head_ent.start,
                                        head_ent.ovf, 1'b0, head_ent.data};

  assert_ack_in_slot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (state_o == 3'd2 || state_o == 3'd4));
  assert_ack_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> (!$past(fifo_full) && !$past(promisc_i)));
  assert_busy_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_write_o, busy_read_o}));
  assert_stop_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_o == 3'd0));
  assert_disabled_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!sda_oe_o && state_o == 3'd0));
endmodule

// File: tb/i2c_srx_test.sv
module i2c_srx_test;
  localparam int DEPTH = 4;
  localparam int HT    = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, scl_m, sda_m, sda_bus, sda_oe;
  logic en, own_en, alt_en, prom, clr, rd_en;
  logic [6:0] own_a, alt_a, alt_m;
  logic [12:0] rd_data;
  logic not_empty, full, bw, br;
  logic [2:0] st;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_srx #(.FIFO_DEPTH(DEPTH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .enable_i(en), .own_en_i(own_en), .own_addr_i(own_a), .alt_en_i(alt_en),
    .alt_addr_i(alt_a), .alt_mask_i(alt_m), .promisc_i(prom), .fifo_clr_i(clr),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .rx_not_empty_o(not_empty),
    .rx_full_o(full), .busy_write_o(bw), .busy_read_o(br), .state_o(st)
  );

  int vec = 0, bad = 0;
  logic [12:0] mq[$];
  bit m_pend = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mpush(bit n, bit p, bit s, logic [7:0] d);
    if (mq.size() == DEPTH) begin
      if (prom) m_pend = 1;
    end else begin
      mq.push_back({n, p, s, m_pend & prom, 1'b0, d});
      m_pend = 0;
    end
  endtask

  task automatic bus_start();
    if (!scl_m) begin
      sda_m = 1; hold(HT); scl_m = 1; hold(HT);
    end
    sda_m = 0; hold(HT); scl_m = 0; hold(HT);
  endtask

  task automatic bus_stop(bit rec);
    sda_m = 0; hold(HT); scl_m = 1; hold(HT); sda_m = 1; hold(HT);
    if (rec) mpush(0, 1, 0, 8'h00);
    hold(4);
  endtask

  task automatic put_byte(string req, logic [7:0] b, bit exp_ack, bit rec, bit s);
    bit acked;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(HT); scl_m = 1; hold(HT); scl_m = 0;
    end
    sda_m = 1; hold(HT); scl_m = 1; hold(HT / 2);
    acked = !sda_bus;
    hold(HT / 2); scl_m = 0;
    chk(req, 32'(acked), 32'(exp_ack));
    if (rec) mpush(!exp_ack, 0, s, b);
    hold(5);
  endtask

  task automatic chk_stat(string req);
    chk(req, 32'(not_empty), 32'(mq.size() > 0));
    chk(req, 32'(full), 32'(mq.size() == DEPTH));
  endtask

  task automatic pop_chk(string req);
    logic [12:0] e;
    e = mq.pop_front();
    chk(req, 32'(rd_data), 32'(e));
    rd_en = 1; @(negedge clk); rd_en = 0;
  endtask

  task automatic drain(string req);
    while (mq.size() > 0) pop_chk(req);
    chk("R13 empty read", 32'(rd_data), 32'h100);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; scl_m = 1; sda_m = 1; en = 1; own_en = 1; own_a = 7'h2A;
    alt_en = 0; alt_a = 7'h50; alt_m = 7'h0F; prom = 0; clr = 0; rd_en = 0;
    hold(3); rst_n = 1; hold(3);

    // reset state
    chk("R13 reset entry", 32'(rd_data), 32'h100);
    chk("R1 reset state", 32'(st), 0);
    chk("R9 reset not_empty", 32'(not_empty), 0);
    chk("R10 reset busy", 32'({bw, br}), 0);
    chk("R2 reset sda_oe", 32'(sda_oe), 0);

    // R2 R5 R9: fixed-address write fills the queue
    bus_start();
    chk("R1 start state", 32'(st), 1);
    put_byte("R2 addr ack", 8'h54, 1, 1, 1);
    chk("R1 data state", 32'(st), 3);
    chk("R10 busy_write", 32'({bw, br}), 32'b10);
    put_byte("R2 data ack", 8'h11, 1, 1, 0);
    put_byte("R2 data ack", 8'h22, 1, 1, 0);
    bus_stop(1);
    chk("R1 stop idle", 32'(st), 0);
    chk("R10 busy clear", 32'({bw, br}), 0);
    chk_stat("R9 full");
    drain("R5 entry");
    chk_stat("R9 empty");

    // R4: mismatch
    bus_start();
    put_byte("R4 mismatch nack", 8'h66, 0, 0, 0);
    chk("R4 idle after mismatch", 32'(st), 0);
    bus_stop(0);
    chk_stat("R4 nothing stored");

    // R3: masked alternate
    own_en = 0; alt_en = 1;
    bus_start();
    put_byte("R3 masked hit", 8'hB4, 1, 1, 1);
    bus_stop(1);
    bus_start();
    put_byte("R3 masked miss", 8'hD4, 0, 0, 0);
    bus_stop(0);
    drain("R3 entry");
    own_en = 1; alt_en = 0;

    // R8: full queue refuses data
    bus_start();
    put_byte("R8 addr", 8'h54, 1, 1, 1);
    put_byte("R8 b1", 8'hA1, 1, 1, 0);
    put_byte("R8 b2", 8'hA2, 1, 1, 0);
    put_byte("R8 b3", 8'hA3, 1, 1, 0);
    put_byte("R8 refused when full", 8'hA4, 0, 0, 0);
    bus_stop(1);
    chk_stat("R8 still full");
    drain("R8 entry no overflow R7");

    // R10: read direction
    bus_start();
    put_byte("R10 read addr ack", 8'h55, 1, 1, 1);
    chk("R10 busy_read", 32'({bw, br}), 32'b01);
    bus_stop(1);
    chk("R10 read cleared", 32'({bw, br}), 0);
    drain("R10 entry");

    // R6: capture mode
    prom = 1; own_en = 0;
    bus_start();
    put_byte("R6 no drive addr", 8'hEE, 0, 1, 1);
    put_byte("R6 no drive data", 8'h01, 0, 1, 0);
    put_byte("R6 no drive data", 8'h02, 0, 1, 0);
    bus_stop(1);
    drain("R6 entry");

    // R7: overflow tag
    bus_start();
    put_byte("R7 fill", 8'h20, 0, 1, 1);
    put_byte("R7 fill", 8'h03, 0, 1, 0);
    put_byte("R7 fill", 8'h04, 0, 1, 0);
    put_byte("R7 fill", 8'h05, 0, 1, 0);
    put_byte("R7 dropped", 8'h06, 0, 1, 0);
    bus_stop(1);
    pop_chk("R7 entry");
    pop_chk("R7 entry");
    bus_start();
    put_byte("R7 tagged", 8'h10, 0, 1, 1);
    bus_stop(1);
    drain("R7 entry");
    prom = 0; own_en = 1;

    // R11: clear
    bus_start();
    put_byte("R11 addr", 8'h54, 1, 1, 1);
    put_byte("R11 data", 8'h99, 1, 1, 0);
    bus_stop(1);
    chk_stat("R11 before clear");
    clr = 1; @(negedge clk); clr = 0;
    mq.delete(); m_pend = 0;
    chk_stat("R11 after clear");
    chk("R11 empty entry", 32'(rd_data), 32'h100);

    // R12: disabled
    en = 0;
    bus_start();
    chk("R12 state idle", 32'(st), 0);
    put_byte("R12 no ack", 8'h54, 0, 0, 0);
    bus_stop(0);
    chk_stat("R12 nothing stored");
    en = 1;
    hold(10);
    finish_run();
  end
endmodule